// File: doc/BRIEF.md
# Two-Controller GPIO Pin Ownership Multiplexer

This block is a GPIO port of parameterizable width. Each pad can be driven by one of two processor-side controllers. The primary controller lives inside the block. It holds five per-pin registers on a simple word-addressed register bus: output data, direction, peripheral select, digital enable and ownership.

The secondary controller sits outside the block. It presents its own output and output-enable vectors and receives the pad input. A dedicated peripheral path (output, output-enable, input) can replace the primary controller's plain data path on any pin that the primary side owns.

Pad inputs are resynchronised by a chain of flops before anything uses them. Pad outputs and enables are registered, so a register write reaches the pad one cycle after it reaches the register. The primary controller keeps read access to a pin's input while the secondary controller owns that pin, as long as the pin's digital enable is set.

Top module: `gpio_own_mux`

## Requirements
- R1: After reset the data, direction, peripheral-select and digital-enable registers read 0. The ownership register reads the parameter OWN_RST, where a 1 bit means the secondary controller owns that pin. pad_oe is 0.
- R2: The registers sit at byte addresses 0x00 (data), 0x04 (direction), 0x08 (peripheral select), 0x0C (digital enable) and 0x10 (ownership). A write stores the low NPINS bits of bus_wdata. Bits at and above NPINS read 0. Any other address reads 0 and writes to it have no effect.
- R3: A written register is visible on bus_rdata in the cycle after the write edge. pad_out and pad_oe reflect the write one clock edge later.
- R4: For a pin with direction 0 and digital enable 1, a read of the data address returns that pad's input delayed by two clock edges.
- R5: On a pin with direction 1, a read of the data address returns the stored data bit. If the pin is primary-owned, has peripheral select 0 and digital enable 1, that bit drives pad_out with pad_oe = 1.
- R6: On a pin with ownership bit 1, pad_out follows sec_out and pad_oe follows sec_oe (when digital enable is 1), each one cycle later.
- R7: On a primary-owned pin with peripheral select 1, pad_out and pad_oe follow alt_out and alt_oe one cycle later. alt_in carries the synchronised pad value on pins with peripheral select 1 and reads 0 on the others.
- R8: On a pin with digital enable 0, pad_oe is 0 whatever the other settings, and a data read of an input pin returns 0.
- R9: A secondary-owned pin with direction 0 and digital enable 1 still returns its synchronised pad value on a data read.
- R10: sec_in always equals the pad input delayed by two clock edges, whatever the ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sec_out | input | NPINS | Secondary controller output values |
| sec_oe | input | NPINS | Secondary controller output enables |
| sec_in | output | NPINS | Synchronised pad input to the secondary controller |
| alt_out | input | NPINS | Peripheral output values |
| alt_oe | input | NPINS | Peripheral output enables |
| alt_in | output | NPINS | Synchronised pad input to the peripheral, gated by peripheral select |
| pad_in | input | NPINS | Pad input values |
| pad_out | output | NPINS | Registered pad output values |
| pad_oe | output | NPINS | Registered pad output enables |

## Verification
The bench builds the block with NPINS = 4 and OWN_RST = 4'b1100, so reset ownership differs from pin to pin. With four control bits per pin, the sweep rotates a mode code through the pins. Every pin passes through all sixteen combinations of direction, peripheral select, digital enable and ownership, each paired with sixteen data patterns on all sources. This reaches every branch of the per-pin mux. Directed cases cover the write-to-pad latency, the two-edge synchroniser delay and the address map edges.

// File: rtl/gpio_own_pkg.sv
package gpio_own_pkg;
   localparam int BUS_W = 32;

   localparam logic [7:0] OFS_DATA = 8'h00;
   localparam logic [7:0] OFS_DIR  = 8'h04;
   localparam logic [7:0] OFS_ALT  = 8'h08;
   localparam logic [7:0] OFS_DEN  = 8'h0C;
   localparam logic [7:0] OFS_OWN  = 8'h10;

   typedef enum logic [2:0] {
      SEL_DATA,
      SEL_DIR,
      SEL_ALT,
      SEL_DEN,
      SEL_OWN,
      SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [7:0] a);
      case (a)
         OFS_DATA: return SEL_DATA;
         OFS_DIR:  return SEL_DIR;
         OFS_ALT:  return SEL_ALT;
         OFS_DEN:  return SEL_DEN;
         OFS_OWN:  return SEL_OWN;
         default:  return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/gpio_own_sync.sv
module gpio_own_sync #(
   parameter int NPINS  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] d,
   output logic [NPINS-1:0] q
);
   logic [STAGES-1:0][NPINS-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_own_regs.sv
module gpio_own_regs
   import gpio_own_pkg::*;
#(
   parameter int               NPINS   = 32,
   parameter int               ADDR_W  = 8,
   parameter logic [NPINS-1:0] OWN_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [NPINS-1:0]  pad_s,
   output logic [BUS_W-1:0]  rdata,
   output logic [NPINS-1:0]  data_q,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  alt_q,
   output logic [NPINS-1:0]  den_q,
   output logic [NPINS-1:0]  own_q
);
   localparam int SEL_W = (ADDR_W < 8) ? ADDR_W : 8;

   reg_sel_e         sel;
   logic [7:0]       addr8;
   logic [NPINS-1:0] wval;
   logic [NPINS-1:0] data_rd;
   logic [NPINS-1:0] rd_mux;

   if (ADDR_W > 8) begin : g_wide
      assign addr8 = (addr[ADDR_W-1:8] == '0) ? addr[7:0] : 8'hFF;
   end else begin : g_narrow
      assign addr8 = 8'(addr[SEL_W-1:0]);
   end

   assign sel  = decode_addr(addr8);
   assign wval = wdata[NPINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         alt_q  <= '0;
         den_q  <= '0;
         own_q  <= OWN_RST;
      end else if (wr) begin
         case (sel)
            SEL_DATA: data_q <= wval;
            SEL_DIR:  dir_q  <= wval;
            SEL_ALT:  alt_q  <= wval;
            SEL_DEN:  den_q  <= wval;
            SEL_OWN:  own_q  <= wval;
            default:  ;
         endcase
      end
   end

   // outputs show stored data, inputs show the synchronised pad when enabled
   assign data_rd = (dir_q & data_q) | (~dir_q & den_q & pad_s);

   always_comb begin
      case (sel)
         SEL_DATA: rd_mux = data_rd;
         SEL_DIR:  rd_mux = dir_q;
         SEL_ALT:  rd_mux = alt_q;
         SEL_DEN:  rd_mux = den_q;
         SEL_OWN:  rd_mux = own_q;
         default:  rd_mux = '0;
      endcase
   end

   assign rdata = BUS_W'(rd_mux);
endmodule

// File: rtl/gpio_own_pinmux.sv
module gpio_own_pinmux #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] data_q,
   input  logic [NPINS-1:0] dir_q,
   input  logic [NPINS-1:0] alt_q,
   input  logic [NPINS-1:0] den_q,
   input  logic [NPINS-1:0] own_q,
   input  logic [NPINS-1:0] sec_out,
   input  logic [NPINS-1:0] sec_oe,
   input  logic [NPINS-1:0] alt_out,
   input  logic [NPINS-1:0] alt_oe,
   input  logic [NPINS-1:0] pad_s,
   output logic [NPINS-1:0] alt_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe
);
   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic prim_out, prim_oe, nxt_out, nxt_oe;

      assign prim_out = alt_q[p] ? alt_out[p] : data_q[p];
      assign prim_oe  = alt_q[p] ? alt_oe[p]  : dir_q[p];
      assign nxt_out  = own_q[p] ? sec_out[p] : prim_out;
      assign nxt_oe   = den_q[p] & (own_q[p] ? sec_oe[p] : prim_oe);
      assign alt_in[p] = alt_q[p] & pad_s[p];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pad_out[p] <= 1'b0;
            pad_oe[p]  <= 1'b0;
         end else begin
            pad_out[p] <= nxt_out;
            pad_oe[p]  <= nxt_oe;
         end
      end
   end
endmodule

// File: rtl/gpio_own_mux.sv
module gpio_own_mux
   import gpio_own_pkg::*;
#(
   parameter int               NPINS       = 32,
   parameter int               ADDR_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [NPINS-1:0] OWN_RST     = NPINS'(32'hFF00_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  sec_out,
   input  logic [NPINS-1:0]  sec_oe,
   output logic [NPINS-1:0]  sec_in,
   input  logic [NPINS-1:0]  alt_out,
   input  logic [NPINS-1:0]  alt_oe,
   output logic [NPINS-1:0]  alt_in,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe
);
   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("gpio_own_mux: NPINS must be 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_own_mux: ADDR_W must reach offset 0x10");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_own_mux: at least two synchroniser stages");
   end

   logic [NPINS-1:0] pad_s;
   logic [NPINS-1:0] data_q, dir_q, alt_q, den_q, own_q;

   gpio_own_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_s)
   );

   gpio_own_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .OWN_RST(OWN_RST)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .pad_s  (pad_s),
      .rdata  (bus_rdata),
      .data_q (data_q),
      .dir_q  (dir_q),
      .alt_q  (alt_q),
      .den_q  (den_q),
      .own_q  (own_q)
   );

   gpio_own_pinmux #(.NPINS(NPINS)) u_mux (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_q  (data_q),
      .dir_q   (dir_q),
      .alt_q   (alt_q),
      .den_q   (den_q),
      .own_q   (own_q),
      .sec_out (sec_out),
      .sec_oe  (sec_oe),
      .alt_out (alt_out),
      .alt_oe  (alt_oe),
      .pad_s   (pad_s),
      .alt_in  (alt_in),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   assign sec_in = pad_s;
endmodule

// File: rtl/gpio_own_chk.sv
module gpio_own_chk #(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [NPINS-1:0]  dir_q,
   input logic [NPINS-1:0]  den_q,
   input logic [NPINS-1:0]  own_q,
   input logic [NPINS-1:0]  sec_oe,
   input logic [NPINS-1:0]  pad_in,
   input logic [NPINS-1:0]  sec_in,
   input logic [NPINS-1:0]  pad_oe
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R8
   den_gates_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0) |-> ((pad_oe & ~$past(den_q)) == '0));

   // R6
   sec_oe_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0) |-> (((pad_oe ^ $past(sec_oe)) & $past(own_q & den_q)) == '0));

   // R10
   sec_in_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (sec_in == $past(pad_in, 2)));

   // R3
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(8'h04)) |=> (dir_q == $past(bus_wdata[NPINS-1:0])));

   // R2
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr > ADDR_W'(8'h10) || bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0));
endmodule

bind gpio_own_mux gpio_own_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .dir_q     (dir_q),
   .den_q     (den_q),
   .own_q     (own_q),
   .sec_oe    (sec_oe),
   .pad_in    (pad_in),
   .sec_in    (sec_in),
   .pad_oe    (pad_oe)
);

// File: tb/tb_gpio_own_mux.sv
`timescale 1ns/1ps
module tb_gpio_own_mux;
   localparam int         N     = 4;
   localparam int         AW    = 8;
   localparam logic [3:0] OWNR  = 4'b1100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  sec_out = '0, sec_oe = '0, alt_out = '0, alt_oe = '0, pad_in = '0;
   logic [N-1:0]  sec_in, alt_in, pad_out, pad_oe;

   int  errors = 0;
   int  checks = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   gpio_own_mux #(.NPINS(N), .ADDR_W(AW), .SYNC_STAGES(2), .OWN_RST(OWNR)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sec_out(sec_out), .sec_oe(sec_oe), .sec_in(sec_in),
      .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r;
      logic [N-1:0] dir, alt, den, own;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(8'h00, r); chk("R1 data", r, 0);
      rd(8'h04, r); chk("R1 dir", r, 0);
      rd(8'h08, r); chk("R1 alt", r, 0);
      rd(8'h0C, r); chk("R1 den", r, 0);
      rd(8'h10, r); chk("R1 own", r, 32'(OWNR));
      chk("R1 pad_oe", 32'(pad_oe), 0);
      rst_n = 1'b1;

      // R2 map, upper bits, unmapped
      wr(8'h04, 32'hFFFF_FFF5); rd(8'h04, r); chk("R2 dir upper bits", r, 32'h5);
      wr(8'h08, 32'h0000_000A); rd(8'h08, r); chk("R2 alt", r, 32'hA);
      wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, r); chk("R2 unmapped read", r, 0);
      rd(8'h04, r); chk("R2 unmapped write no effect dir", r, 32'h5);
      rd(8'h08, r); chk("R2 unmapped write no effect alt", r, 32'hA);
      rd(8'h06, r); chk("R2 misaligned read", r, 0);
      rd(8'h10, r); chk("R2 own kept", r, 32'(OWNR));

      // R3 latency: register now, pad one edge later
      wr(8'h08, 0); wr(8'h10, 0); wr(8'h0C, 32'hF); wr(8'h04, 0);
      @(negedge clk);
      wr(8'h04, 32'h3);
      rd(8'h04, r); chk("R3 reg visible", r, 32'h3);
      chk("R3 pad_oe not yet", 32'(pad_oe), 0);
      @(negedge clk);
      chk("R3 pad_oe after one edge", 32'(pad_oe), 32'h3);

      // R4 two-edge synchroniser on input pins
      wr(8'h04, 0);
      pad_in = 4'b1010;
      rd(8'h00, r); chk("R4 before edges", r, 0);
      @(negedge clk); rd(8'h00, r); chk("R4 after one edge", r, 0);
      @(negedge clk); rd(8'h00, r); chk("R4 after two edges", r, 32'hA);
      chk("R10 sec_in", 32'(sec_in), 32'hA);

      // R9 secondary-owned pin still readable
      wr(8'h10, 32'hF); rd(8'h00, r); chk("R9 read while secondary owns", r, 32'hA);

      // sweep: each pin runs through all 16 mode codes, 16 data patterns each
      for (int m = 0; m < 16; m++) begin
         for (int p = 0; p < N; p++) begin
            logic [3:0] code;
            code = 4'((m + 4 * p) % 16);
            dir[p] = code[0]; alt[p] = code[1]; den[p] = code[2]; own[p] = code[3];
         end
         wr(8'h04, 32'(dir)); wr(8'h08, 32'(alt));
         wr(8'h0C, 32'(den)); wr(8'h10, 32'(own));
         for (int d = 0; d < 16; d++) begin
            logic [N-1:0] dv, eo, eoe;
            dv = 4'(d);
            @(negedge clk);
            bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'(dv);
            sec_out = {dv[0], dv[3:1]}; sec_oe = ~dv;
            alt_out = dv ^ 4'h6; alt_oe = {dv[1:0], dv[3:2]};
            pad_in = dv ^ 4'h9;
            @(negedge clk); bus_wr = 1'b0;
            @(negedge clk);
            eo  = (own & sec_out) | (~own & ((alt & alt_out) | (~alt & dv)));
            eoe = den & ((own & sec_oe) | (~own & ((alt & alt_oe) | (~alt & dir))));
            chk("R5 R6 R7 pad_out", 32'(pad_out), 32'(eo));
            chk("R5 R6 R7 R8 pad_oe", 32'(pad_oe), 32'(eoe));
            chk("R10 sec_in", 32'(sec_in), 32'(pad_in));
            chk("R7 alt_in", 32'(alt_in), 32'(alt & pad_in));
            rd(8'h00, r);
            chk("R4 R5 R8 R9 data read", r, 32'((dir & dv) | (~dir & den & pad_in)));
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule